// File: doc/BRIEF.md
# Switching Supply Start-up and Fault Supervisor

This block is the digital supervisor of an off-line switching regulator controller. It decides cycle by cycle whether the power switch may be driven. It also decides when the high-voltage start-up current source charges the controller's own supply capacitor. All inputs are digital flags that come from analog comparators outside the block. Six flags describe the supply rail: start level reached, stop level reached, undervoltage-lockout level reached, latch-release level reached, clear level reached, and over-voltage. Five more flags report bulk brown-out, an external disable, an external permanent-latch request, over-temperature and overload. The block has three outputs: a switching enable, a one-cycle restart strobe that the soft-start circuit uses, and the start-up source enable.

In normal operation the start-up source works with hysteresis between the stop level and the start level. A sustained overload is timed by a fault counter. When the counter expires, the block enters a protection state. In that state the start-up source only turns on at the much lower latch-release level, and the block waits for a set number of recharges before it restarts. An external latch request locks the output off until the supply collapses below the clear level. The block has one clock domain and an active-low asynchronous reset.

Top module: `supply_supervisor`

## Requirements
- R1: After reset, swEnable and restartPulse are 0 and hvSrcEn is 1. The block waits in the off state until supAboveStart is seen.
- R2: In the off state, supAboveStart sets swEnable and clears hvSrcEn on the next clock edge.
- R3: Outside protection and latch, hvSrcEn goes to 1 one edge after supBelowStop and to 0 one edge after supAboveStart, and holds its value otherwise. hvSrcEn never rises unless a low-supply flag (supBelowStop, supBelowLatch or supBelowClear) was high on the edge before.
- R4: While running, any of supOver, bulkLow, extDisable or hotDie clears swEnable on the next edge. When all four are low again, swEnable returns on the next edge with a restart strobe.
- R5: In the running state, overload held high for FAULT_CYCLES consecutive edges clears swEnable on the last of those edges. A burst shorter than that has no effect, and when overload drops the count restarts from zero.
- R6: The fault count also advances while switching is held off by an R4 condition, so an expiry during such a stop still leads to protection.
- R7: On entry to protection, hvSrcEn goes to 0. In protection, hvSrcEn goes to 1 on supBelowLatch and to 0 on supAboveStart. swEnable stays 0 through the first RECHARGES-1 recharges. On the edge that ends recharge number RECHARGES, switching restarts with a restart strobe.
- R8: supBelowUvlo while hvSrcEn is 1 enters protection (swEnable 0, hvSrcEn 0). supBelowUvlo while hvSrcEn is 0 has no effect.
- R9: extLatch clears swEnable and hvSrcEn on the next edge. The source then cycles between the latch-release and start levels, and switching stays off however many recharges occur. Only supBelowClear with extLatch low leaves the latch; it returns the block to the off state with hvSrcEn at 1.
- R10: The latch has priority over protection: an extLatch request during protection blocks the restart that the recharges would otherwise give.
- R11: restartPulse is high for exactly one cycle, in the first cycle of each 0-to-1 change of swEnable, and is never high at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supAboveStart | input | 1 | Supply at or above start level |
| supBelowStop | input | 1 | Supply at or below stop level |
| supBelowUvlo | input | 1 | Supply at or below undervoltage-lockout level |
| supBelowLatch | input | 1 | Supply at or below latch-release level |
| supBelowClear | input | 1 | Supply below latch clear level |
| supOver | input | 1 | Supply over-voltage |
| bulkLow | input | 1 | Bulk voltage brown-out |
| extDisable | input | 1 | External disable request |
| extLatch | input | 1 | External permanent latch request |
| hotDie | input | 1 | Over-temperature |
| overload | input | 1 | Feedback asks for maximum power |
| swEnable | output | 1 | Switching allowed |
| restartPulse | output | 1 | One-cycle soft-start trigger |
| hvSrcEn | output | 1 | Start-up current source enable |

## Verification
A wrong internal state shows at the ports within one clock edge of the next supply flag. A lost recharge count restarts switching one recharge too early or too late. A fault timer that does not clear trips protection after a split overload, one edge after the count wraps into its limit. A block left in protection or latch by mistake shows up as hvSrcEn rising at the latch-release flag instead of the stop flag. swEnable also stays low after the restart that was due. Every such divergence is therefore visible on swEnable or hvSrcEn on the edge after the stimulus that should have caused or prevented it.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_RUN   = 2'd1,
    ST_PROT  = 2'd2,
    ST_LATCH = 2'd3
  } sup_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic timerRun;
    logic rechargeClr;
    logic rechargeInc;
    logic hvSet;
    logic hvClr;
  } sup_strobe_t;

endpackage

// File: rtl/sup_dpath.sv
module sup_dpath
  import sup_pkg::*;
#(
  parameter int FAULT_CYCLES = 64,
  parameter int RECHARGES    = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        overload,
  input  sup_strobe_t stb,
  output logic        timerExpired,
  output logic        rechargeDone,
  output logic        hvOn
);

  localparam int TW = $clog2(FAULT_CYCLES) + 1;
  localparam int RW = $clog2(RECHARGES) + 1;
  localparam logic [TW-1:0] TIMER_LAST  = TW'(FAULT_CYCLES - 1);
  localparam logic [RW-1:0] RECHG_LIMIT = RW'(RECHARGES);

  logic [TW-1:0] faultCnt;
  logic [RW-1:0] rechgCnt;

  // overload timer: counts consecutive overload cycles while enabled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultCnt <= '0;
    end else if (!stb.timerRun || !overload) begin
      faultCnt <= '0;
    end else if (faultCnt != TIMER_LAST) begin
      faultCnt <= faultCnt + 1'b1;
    end
  end

  assign timerExpired = stb.timerRun && overload && (faultCnt == TIMER_LAST);

  // recharge counter used in protection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rechgCnt <= '0;
    end else if (stb.rechargeClr) begin
      rechgCnt <= '0;
    end else if (stb.rechargeInc && (rechgCnt != RECHG_LIMIT)) begin
      rechgCnt <= rechgCnt + 1'b1;
    end
  end

  assign rechargeDone = (rechgCnt == RECHG_LIMIT);

  // start-up source state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hvOn <= 1'b1;
    end else if (stb.hvSet) begin
      hvOn <= 1'b1;
    end else if (stb.hvClr) begin
      hvOn <= 1'b0;
    end
  end

endmodule

// File: rtl/sup_ctrl.sv
module sup_ctrl
  import sup_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        supAboveStart,
  input  logic        supBelowStop,
  input  logic        supBelowUvlo,
  input  logic        supBelowLatch,
  input  logic        supBelowClear,
  input  logic        supOver,
  input  logic        bulkLow,
  input  logic        extDisable,
  input  logic        extLatch,
  input  logic        hotDie,
  input  logic        timerExpired,
  input  logic        rechargeDone,
  input  logic        hvOn,
  output sup_strobe_t stb,
  output logic        swEnable,
  output logic        restartPulse
);

  sup_state_t state, nextState;
  logic       stopCond;
  logic       runNext;

  assign stopCond = supOver || bulkLow || extDisable || hotDie;

  always_comb begin
    nextState = state;
    stb       = '0;
    if (extLatch && (state != ST_LATCH)) begin
      nextState = ST_LATCH;
      stb.hvClr = 1'b1;
    end else begin
      unique case (state)
        ST_OFF: begin
          if (supAboveStart) begin
            nextState = ST_RUN;
            stb.hvClr = 1'b1;
          end
        end
        ST_RUN: begin
          stb.timerRun = 1'b1;
          if (timerExpired || (hvOn && supBelowUvlo)) begin
            nextState       = ST_PROT;
            stb.hvClr       = 1'b1;
            stb.rechargeClr = 1'b1;
          end else if (supBelowStop) begin
            stb.hvSet = 1'b1;
          end else if (supAboveStart) begin
            stb.hvClr = 1'b1;
          end
        end
        ST_PROT: begin
          if (!hvOn && supBelowLatch) begin
            stb.hvSet       = 1'b1;
            stb.rechargeInc = 1'b1;
          end else if (hvOn && supAboveStart) begin
            stb.hvClr = 1'b1;
            if (rechargeDone) begin
              nextState = ST_RUN;
            end
          end
        end
        ST_LATCH: begin
          if (supBelowClear && !extLatch) begin
            nextState = ST_OFF;
            stb.hvSet = 1'b1;
          end else if (!hvOn && supBelowLatch) begin
            stb.hvSet = 1'b1;
          end else if (hvOn && supAboveStart) begin
            stb.hvClr = 1'b1;
          end
        end
        default: nextState = ST_OFF;
      endcase
    end
  end

  assign runNext = (nextState == ST_RUN) && !stopCond;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_OFF;
      swEnable     <= 1'b0;
      restartPulse <= 1'b0;
    end else begin
      state        <= nextState;
      swEnable     <= runNext;
      restartPulse <= runNext && !swEnable;
    end
  end

endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import sup_pkg::*;
#(
  parameter int FAULT_CYCLES = 64,
  parameter int RECHARGES    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic supAboveStart,
  input  logic supBelowStop,
  input  logic supBelowUvlo,
  input  logic supBelowLatch,
  input  logic supBelowClear,
  input  logic supOver,
  input  logic bulkLow,
  input  logic extDisable,
  input  logic extLatch,
  input  logic hotDie,
  input  logic overload,
  output logic swEnable,
  output logic restartPulse,
  output logic hvSrcEn
);

  sup_strobe_t stb;
  logic        timerExpired;
  logic        rechargeDone;
  logic        hvOn;

  sup_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .supAboveStart(supAboveStart),
    .supBelowStop (supBelowStop),
    .supBelowUvlo (supBelowUvlo),
    .supBelowLatch(supBelowLatch),
    .supBelowClear(supBelowClear),
    .supOver      (supOver),
    .bulkLow      (bulkLow),
    .extDisable   (extDisable),
    .extLatch     (extLatch),
    .hotDie       (hotDie),
    .timerExpired (timerExpired),
    .rechargeDone (rechargeDone),
    .hvOn         (hvOn),
    .stb          (stb),
    .swEnable     (swEnable),
    .restartPulse (restartPulse)
  );

  sup_dpath #(
    .FAULT_CYCLES(FAULT_CYCLES),
    .RECHARGES   (RECHARGES)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .overload    (overload),
    .stb         (stb),
    .timerExpired(timerExpired),
    .rechargeDone(rechargeDone),
    .hvOn        (hvOn)
  );

  assign hvSrcEn = hvOn;

endmodule

// File: rtl/supply_supervisor_chk.sv
module supply_supervisor_chk (
  input logic clk,
  input logic rstN,
  input logic supBelowStop,
  input logic supBelowLatch,
  input logic supBelowClear,
  input logic supOver,
  input logic bulkLow,
  input logic extDisable,
  input logic extLatch,
  input logic hotDie,
  input logic swEnable,
  input logic restartPulse,
  input logic hvSrcEn
);

  // R11
  strobe_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    restartPulse |-> (swEnable && !$past(swEnable)));

  // R11
  rise_gives_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(swEnable) |-> restartPulse);

  // R4
  stop_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    (supOver || bulkLow || extDisable || hotDie) |=> !swEnable);

  // R9
  perm_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    extLatch |=> (!swEnable && !restartPulse));

  // R3
  hv_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hvSrcEn) |-> $past(supBelowStop || supBelowLatch || supBelowClear));

endmodule

bind supply_supervisor supply_supervisor_chk u_chk (.*);

// File: tb/tb_supply_supervisor.sv
`timescale 1ns/1ps
module tb_supply_supervisor;

  localparam int FAULTS = 64;
  localparam int RECH   = 2;

  logic clk = 1'b0;
  logic rstN;
  logic supAboveStart, supBelowStop, supBelowUvlo, supBelowLatch, supBelowClear;
  logic supOver, bulkLow, extDisable, extLatch, hotDie, overload;
  logic swEnable, restartPulse, hvSrcEn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  supply_supervisor #(.FAULT_CYCLES(FAULTS), .RECHARGES(RECH)) dut (.*);

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic chkOut(input string req, input logic sw, input logic rs, input logic hv);
    chk(req, "swEnable", swEnable, sw);
    chk(req, "restartPulse", restartPulse, rs);
    chk(req, "hvSrcEn", hvSrcEn, hv);
  endtask

  // one recharge in protection or latch: latch-level dip then start level
  task automatic recharge(input string req, input logic swAfter);
    supBelowLatch = 1'b1; tick(1); supBelowLatch = 1'b0;
    chk(req, "hv on at latch level", hvSrcEn, 1'b1);
    chk(req, "sw off while charging", swEnable, 1'b0);
    supAboveStart = 1'b1; tick(1); supAboveStart = 1'b0;
    chk(req, "hv off at start level", hvSrcEn, 1'b0);
    chk(req, "sw after recharge", swEnable, swAfter);
    chk(req, "strobe after recharge", restartPulse, swAfter);
    tick(1);
    chk(req, "strobe one cycle", restartPulse, 1'b0);
  endtask

  task automatic testReset();
    chkOut("R1", 1'b0, 1'b0, 1'b1);
    tick(3);
    chkOut("R1", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic testStartup();
    supAboveStart = 1'b1; tick(1);
    chkOut("R2", 1'b1, 1'b1, 1'b0);
    supAboveStart = 1'b0; tick(1);
    chkOut("R11", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testHysteresis();
    supBelowStop = 1'b1; tick(1); supBelowStop = 1'b0;
    chkOut("R3", 1'b1, 1'b0, 1'b1);
    tick(2);
    chk("R3", "hv holds between levels", hvSrcEn, 1'b1);
    supAboveStart = 1'b1; tick(1); supAboveStart = 1'b0;
    chkOut("R3", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testStopConds();
    for (int i = 0; i < 4; i++) begin
      supOver = (i == 0); bulkLow = (i == 1); extDisable = (i == 2); hotDie = (i == 3);
      tick(1);
      chk("R4", "sw off under stop condition", swEnable, 1'b0);
      tick(2);
      chk("R4", "sw stays off", swEnable, 1'b0);
      supOver = 1'b0; bulkLow = 1'b0; extDisable = 1'b0; hotDie = 1'b0;
      tick(1);
      chk("R4", "sw resumes", swEnable, 1'b1);
      chk("R11", "strobe on resume", restartPulse, 1'b1);
      tick(1);
      chk("R11", "strobe one cycle", restartPulse, 1'b0);
    end
  endtask

  task automatic testShortOverload();
    overload = 1'b1; tick(FAULTS - 1); overload = 1'b0;
    chk("R5", "burst just short of limit", swEnable, 1'b1);
    tick(1);
    overload = 1'b1; tick(FAULTS - 1); overload = 1'b0;
    chk("R5", "timer cleared between bursts", swEnable, 1'b1);
    tick(1);
    chk("R5", "still running", swEnable, 1'b1);
  endtask

  task automatic testProtection();
    overload = 1'b1; tick(FAULTS - 1);
    chk("R5", "one edge before expiry", swEnable, 1'b1);
    tick(1); overload = 1'b0;
    chkOut("R5", 1'b0, 1'b0, 1'b0);
    supBelowStop = 1'b1; tick(1); supBelowStop = 1'b0;
    chk("R7", "stop level ignored in protection", hvSrcEn, 1'b0);
    recharge("R7", 1'b0);
    recharge("R7", 1'b1);
  endtask

  task automatic testTimerWhileStopped();
    bulkLow = 1'b1; overload = 1'b1; tick(FAULTS);
    bulkLow = 1'b0; overload = 1'b0; tick(1);
    chk("R6", "protection after timeout while stopped", swEnable, 1'b0);
    chk("R6", "hv off in protection", hvSrcEn, 1'b0);
    recharge("R6", 1'b0);
    recharge("R6", 1'b1);
  endtask

  task automatic testUvlo();
    supBelowUvlo = 1'b1; tick(2);
    chkOut("R8", 1'b1, 1'b0, 1'b0);
    supBelowStop = 1'b1; tick(1);
    chkOut("R8", 1'b1, 1'b0, 1'b1);
    tick(1);
    supBelowStop = 1'b0; supBelowUvlo = 1'b0;
    chkOut("R8", 1'b0, 1'b0, 1'b0);
    recharge("R8", 1'b0);
    recharge("R8", 1'b1);
  endtask

  task automatic testLatch();
    extLatch = 1'b1; tick(1); extLatch = 1'b0;
    chkOut("R9", 1'b0, 1'b0, 1'b0);
    recharge("R9", 1'b0);
    recharge("R9", 1'b0);
    recharge("R9", 1'b0);
    supBelowClear = 1'b1; tick(1); supBelowClear = 1'b0;
    chkOut("R9", 1'b0, 1'b0, 1'b1);
    supAboveStart = 1'b1; tick(1); supAboveStart = 1'b0;
    chkOut("R9", 1'b1, 1'b1, 1'b0);
    tick(1);
  endtask

  task automatic testPriority();
    overload = 1'b1; tick(FAULTS); overload = 1'b0;
    chk("R10", "in protection", swEnable, 1'b0);
    recharge("R10", 1'b0);
    extLatch = 1'b1; tick(1); extLatch = 1'b0;
    chk("R10", "latch hv off", hvSrcEn, 1'b0);
    recharge("R10", 1'b0);
    recharge("R10", 1'b0);
    supBelowClear = 1'b1; tick(1); supBelowClear = 1'b0;
    supAboveStart = 1'b1; tick(1); supAboveStart = 1'b0;
    chk("R10", "restart after clear", swEnable, 1'b1);
    tick(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=timeout expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    {supAboveStart, supBelowStop, supBelowUvlo, supBelowLatch, supBelowClear} = '0;
    {supOver, bulkLow, extDisable, extLatch, hotDie, overload} = '0;
    tick(3);
    rstN = 1'b1;
    testReset();
    testStartup();
    testHysteresis();
    testStopConds();
    testShortOverload();
    testProtection();
    testTimerWhileStopped();
    testUvlo();
    testLatch();
    testPriority();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule